// File: doc/BRIEF.md
# Asynchronous CPU Bus Write Capture

This block is a write-only slave for an 8-bit microprocessor bus whose cycle clock has no fixed relation to the fast system clock. On the falling transition of the bus clock, a small bank of capture flops takes in the chip select, the read/write strobe, the register address and the data byte. The bus clock itself goes into the system domain through a flop chain and then a stability filter. The filter absorbs the ringing that slow edges produce. A falling edge of the filtered level marks the end of a bus cycle.

One system cycle after that edge, the block stages the captured values. If the cycle was a selected write, it commits the byte into an internal register file indexed by the captured address. Logic on the system side reads the register file through its own address port. That read port is registered. The only logic clocked by the bus clock is the capture bank. Everything else runs on the system clock.

Top module: `cpu_wr_capture`

## Requirements
- R1: The address, data, `bus_sel_n` and `bus_rd_wr` are latched at the falling transition of `bus_clk`. A change on those inputs a few nanoseconds after the final falling transition does not alter the value stored.
- R2: `bus_clk` passes through `SYNC_STAGES` (at least 2) system-clock flops before any logic uses it. A write is not visible at `rd_data` within 5 system clocks of the final bus clock fall.
- R3: The filtered bus clock level changes only after the synchronized value has disagreed with it for `FILT_CYC` consecutive system clocks. Pulses shorter than that are ignored, so a ringing edge yields one edge.
- R4: A falling edge is detected when the filtered level goes from 1 to 0. The detection pulse lasts one system cycle.
- R5: The commit happens one system cycle after the detected falling edge, and each bus cycle gives at most one write. The byte is readable at `rd_data` within 9 system clocks of the final bus clock fall.
- R6: A write is committed only when the captured `bus_sel_n` is 0 and the captured `bus_rd_wr` is 0 (0 = write, 1 = read). Read cycles and deselected cycles leave the contents unchanged.
- R7: `rd_data` is registered. It shows the entry at `rd_addr` one system clock edge after `rd_addr` changes, and it does not change before that edge.
- R8: Synchronous active-high `rst` clears the synchronizer, the filter, the edge history, the staging, all entries and `rd_data` (which reads 0). After reset, no write occurs until a full high-then-low bus clock sequence has been observed. A write that was captured before or during reset is never committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_clk | input | 1 | CPU bus cycle clock, asynchronous |
| bus_sel_n | input | 1 | Chip select, active low |
| bus_rd_wr | input | 1 | 1 = read cycle, 0 = write cycle |
| bus_addr | input | ADDR_W | Register address from the CPU |
| bus_data | input | DATA_W | Write data from the CPU |
| rd_addr | input | ADDR_W | System-side read address |
| rd_data | output | DATA_W | Registered read data, one cycle of latency |

## Verification
The bench builds the block with its defaults: a 3-bit address (eight entries), 8-bit data, two synchronizer stages and a three-cycle filter. This small configuration lets each pass write every entry with an arithmetically derived byte and read all of them back. Each write is surrounded by a read cycle and a deselected cycle, and short glitches are injected on both bus clock edges. The bus clock period is not a multiple of the system clock period, and the bus inputs change 8 ns after the last fall. This exercises the phase spread, the ringing rejection and the capture-at-transition behaviour. The eight first-pass writes are also timed against the synchronizer-plus-filter latency bounds.

// File: rtl/cwc_pkg.sv
`timescale 1ns/1ps
package cwc_pkg;
   // control half of a captured bus cycle
   typedef struct packed {
      logic sel_n;
      logic rd_wr;
   } cwc_ctl_t;

   localparam cwc_ctl_t CWC_CTL_IDLE = '{sel_n: 1'b1, rd_wr: 1'b1};
endpackage

// File: rtl/cwc_sync.sv
`timescale 1ns/1ps
module cwc_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic din,
   output logic dout
);
   if (STAGES < 2) begin : g_bad_stages
      $error("cwc_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-2:0], din};
   end

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/cwc_deglitch.sv
`timescale 1ns/1ps
module cwc_deglitch #(
   parameter int FILT_CYC = 3
) (
   input  logic clk,
   input  logic rst,
   input  logic din,
   output logic lvl
);
   if (FILT_CYC < 1) begin : g_bad_filt
      $error("cwc_deglitch: FILT_CYC must be at least 1");
   end

   if (FILT_CYC == 1) begin : g_pass
      always_ff @(posedge clk) begin
         if (rst) lvl <= 1'b0;
         else     lvl <= din;
      end
   end else begin : g_count
      localparam int CW = $clog2(FILT_CYC);
      localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);
      logic [CW-1:0] run;

      always_ff @(posedge clk) begin
         if (rst) begin
            lvl <= 1'b0;
            run <= '0;
         end else if (din == lvl) begin
            run <= '0;
         end else if (run == LAST) begin
            lvl <= din;
            run <= '0;
         end else begin
            run <= run + 1'b1;
         end
      end
   end

   // R3: the level only moves toward a disagreeing input
   a_r3_level_follows_input: assert property (@(posedge clk) disable iff (rst)
      (lvl != $past(lvl)) |-> ($past(din) != $past(lvl)));
endmodule

// File: rtl/cwc_regfile.sv
`timescale 1ns/1ps
module cwc_regfile #(
   parameter int ADDR_W = 3,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   if (ADDR_W < 1 || ADDR_W > 8) begin : g_bad_aw
      $error("cwc_regfile: ADDR_W out of range");
   end

   logic [DATA_W-1:0] cells [DEPTH];

   // read sees the old content when a write hits the same entry
   always_ff @(posedge clk) begin
      if (rst) rdata <= '0;
      else     rdata <= cells[raddr];
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_cell
      always_ff @(posedge clk) begin
         if (rst)                                    cells[i] <= '0;
         else if (we && waddr == ADDR_W'(i))         cells[i] <= wdata;
      end
   end
endmodule

// File: rtl/cpu_wr_capture.sv
`timescale 1ns/1ps
module cpu_wr_capture #(
   parameter int ADDR_W      = 3,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int FILT_CYC    = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              bus_clk,
   input  logic              bus_sel_n,
   input  logic              bus_rd_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   import cwc_pkg::*;

   if (DATA_W < 1) begin : g_bad_dw
      $error("cpu_wr_capture: DATA_W must be positive");
   end

   // capture bank: the only flops on the bus clock (R1)
   cwc_ctl_t          cap_ctl;
   logic [ADDR_W-1:0] cap_addr;
   logic [DATA_W-1:0] cap_data;

   always_ff @(negedge bus_clk) begin
      cap_ctl  <= '{sel_n: bus_sel_n, rd_wr: bus_rd_wr};
      cap_addr <= bus_addr;
      cap_data <= bus_data;
   end

   // system-domain view of the bus clock (R2, R3)
   logic bclk_sync, bclk_lvl;

   cwc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk), .rst (rst), .din (bus_clk), .dout (bclk_sync)
   );

   cwc_deglitch #(.FILT_CYC(FILT_CYC)) u_filt (
      .clk (clk), .rst (rst), .din (bclk_sync), .lvl (bclk_lvl)
   );

   // edge history (R4)
   logic lvl_prev, fall;

   always_ff @(posedge clk) begin
      if (rst) lvl_prev <= 1'b0;
      else     lvl_prev <= bclk_lvl;
   end

   assign fall = lvl_prev & ~bclk_lvl;

   // staging one cycle after the edge (R5, R6)
   cwc_ctl_t          stg_ctl;
   logic              commit;
   logic [ADDR_W-1:0] stg_addr;
   logic [DATA_W-1:0] stg_data;

   always_ff @(posedge clk) begin
      if (rst) begin
         stg_ctl  <= CWC_CTL_IDLE;
         commit   <= 1'b0;
         stg_addr <= '0;
         stg_data <= '0;
      end else begin
         commit <= fall & ~cap_ctl.sel_n & ~cap_ctl.rd_wr;
         if (fall) begin
            stg_ctl  <= cap_ctl;
            stg_addr <= cap_addr;
            stg_data <= cap_data;
         end
      end
   end

   cwc_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rf (
      .clk   (clk),
      .rst   (rst),
      .we    (commit),
      .waddr (stg_addr),
      .wdata (stg_data),
      .raddr (rd_addr),
      .rdata (rd_data)
   );

   // R4: an edge pulse never lasts two cycles
   a_r4_fall_single: assert property (@(posedge clk) disable iff (rst)
      fall |=> !fall);

   // R5: a commit always follows a detected fall by one cycle
   a_r5_commit_after_fall: assert property (@(posedge clk) disable iff (rst)
      commit |-> $past(fall));

   // R5: never two writes back to back
   a_r5_commit_single: assert property (@(posedge clk) disable iff (rst)
      commit |=> !commit);

   // R6: only selected write cycles are committed
   a_r6_commit_needs_write: assert property (@(posedge clk) disable iff (rst)
      commit |-> (!stg_ctl.sel_n && !stg_ctl.rd_wr));
endmodule

// File: tb/tb_cpu_wr_capture.sv
`timescale 1ns/1ps
module tb_cpu_wr_capture;
   localparam int AW = 3;
   localparam int DW = 8;
   localparam int N  = 1 << AW;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          bus_clk = 1'b0;
   logic          bus_sel_n = 1'b1;
   logic          bus_rd_wr = 1'b1;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_data = '0;
   logic [AW-1:0] rd_addr = '0;
   logic [DW-1:0] rd_data;

   int total = 0;
   int bad   = 0;
   logic [DW-1:0] model [N];

   always #10 clk = ~clk;

   cpu_wr_capture #(.ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(2), .FILT_CYC(3)) dut (
      .clk (clk), .rst (rst), .bus_clk (bus_clk), .bus_sel_n (bus_sel_n),
      .bus_rd_wr (bus_rd_wr), .bus_addr (bus_addr), .bus_data (bus_data),
      .rd_addr (rd_addr), .rd_data (rd_data)
   );

   task automatic check(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: got %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] pat(input int a, input int p);
      return DW'((a * 29 + p * 71 + 5) & 8'hFF);
   endfunction

   // low phase with bus values set, ringing rise, high phase
   task automatic bus_front(input logic sn, input logic rw, input logic [AW-1:0] a, input logic [DW-1:0] d);
      bus_sel_n = sn; bus_rd_wr = rw; bus_addr = a; bus_data = d;
      #213;
      bus_clk = 1'b1; #5; bus_clk = 1'b0; #6; bus_clk = 1'b1; #4;
      bus_clk = 1'b0; #5; bus_clk = 1'b1;
      #331;
   endtask

   // ringing fall, then bus values change 8 ns after the final fall (R1)
   task automatic bus_fall();
      bus_clk = 1'b0; #4; bus_clk = 1'b1; #5; bus_clk = 1'b0; #6;
      bus_clk = 1'b1; #3; bus_clk = 1'b0;
      #8;
      bus_addr = bus_addr ^ AW'(1);
      bus_data = ~bus_data;
   endtask

   task automatic bus_cycle(input logic sn, input logic rw, input logic [AW-1:0] a, input logic [DW-1:0] d);
      bus_front(sn, rw, a, d);
      bus_fall();
      #247;
   endtask

   task automatic read_chk(input int a, input logic [DW-1:0] exp, input string tag);
      @(negedge clk); rd_addr = AW'(a);
      @(negedge clk);
      check(rd_data, exp, tag);
   endtask

   initial begin : watchdog
      #(20 * 200000);
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      for (int i = 0; i < N; i++) model[i] = '0;

      // R8: a write captured during reset is dropped
      bus_sel_n = 1'b0; bus_rd_wr = 1'b0; bus_addr = 3'd5; bus_data = 8'hAA;
      #100; bus_clk = 1'b1; #200; bus_clk = 1'b0; #100;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      repeat (2) @(negedge clk);
      check(rd_data, 8'h00, "R8 reset read data");
      repeat (30) @(negedge clk);
      read_chk(5, 8'h00, "R8 no write without full high-low after reset");

      // R7: registered read, one edge of latency
      bus_cycle(1'b0, 1'b0, 3'd2, 8'h3C);
      model[2] = 8'h3C;
      repeat (20) @(negedge clk);
      rd_addr = 3'd0;
      @(negedge clk);
      rd_addr = 3'd2;
      #3;
      check(rd_data, 8'h00, "R7 rd_data unchanged before edge");
      @(negedge clk);
      check(rd_data, 8'h3C, "R7 rd_data after one edge");

      for (int p = 0; p < 4; p++) begin
         for (int a = 0; a < N; a++) begin
            logic [DW-1:0] old_v;
            old_v = model[a];
            if (p == 0) begin
               // R2 / R5 latency window of a single write
               @(negedge clk); rd_addr = AW'(a);
               bus_front(1'b0, 1'b0, AW'(a), pat(a, p));
               bus_fall();
               repeat (4) @(posedge clk);
               #3;
               check(rd_data, old_v, "R2 write not visible before sync and filter");
               repeat (5) @(posedge clk);
               #3;
               check(rd_data, pat(a, p), "R5 write visible within bound");
               #100;
            end else begin
               bus_cycle(1'b0, 1'b0, AW'(a), pat(a, p));   // R1 R3 R4 R5
            end
            model[a] = pat(a, p);
            bus_cycle(1'b0, 1'b1, AW'(a), 8'h5A);            // R6 read cycle
            bus_cycle(1'b1, 1'b0, AW'((a + 3) % N), 8'hC3);  // R6 deselected
         end
         repeat (20) @(negedge clk);
         for (int a = 0; a < N; a++)
            read_chk(a, model[a], "R1 R3 R6 entry after pass");
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule